// File: doc/BRIEF.md
# Power-Fail Write Guard with Battery Test Sequencer

This block sits between a host and a battery-backed static memory. It passes the host's chip-enable and write-enable strobes to the memory, but only while the supply is healthy. As soon as the supply is reported lost, it forces both strobes inactive and asserts a system reset. When the supply returns, it holds the strobes off for a short settling window. It keeps writes blocked for a longer protection window, and then releases reset after a longer delay still. It also decides when the memory's output buffers may drive the shared data bus. Drive is never allowed during a write, or during an access that began with write-enable already low.

A second function runs a periodic battery load test. The first test starts as soon as power is good, and later tests follow at a fixed period measured in powered cycles. The battery comparator is sampled once, at the edge that ends each test pulse. The result is held in a latched warning flag until a later test overwrites it.

All windows are given in milliseconds and converted to cycle counts from a clock-frequency parameter. Supply loss at any point aborts the power-up sequence and any running test pulse. Every timer then starts again from zero at the next powered cycle.

Top module: `pwrfail_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mem_ce_n`=1, `mem_we_n`=1, `buf_drive`=0, `sys_rst`=1, `bat_load`=0 and `bat_warn`=0.
- R2: A clock edge that samples `supply_fail`=1 or `supply_good`=0 (unpowered) sets `mem_ce_n`=1, `mem_we_n`=1 and `sys_rst`=1 at that same edge.
- R3: Counting powered edges from 1 after supply returns, `mem_ce_n` is forced to 1 through edge G-1. From edge G onward it equals `host_ce_n` as sampled at that edge. Here G = CLK_HZ*GATE_MS/1000, with a minimum of 1.
- R4: On the same edge count, `mem_we_n` is forced to 1 through edge W-1. From edge W onward it equals `host_we_n` as sampled at that edge. Here W = CLK_HZ*PROT_MS/1000.
- R5: `sys_rst` stays 1 through powered edge S-1 and is 0 from edge S onward. Here S = CLK_HZ*RST_MS/1000 and S ≥ W ≥ G.
- R6: Any unpowered edge during the sequence restarts the edge count. After the supply returns, the windows of R3 to R5 are measured again from edge 1.
- R7: An access begins at an edge where the gated chip-enable is low and was high at the edge before. If `host_we_n`=0 at that edge, the access is write-first until the gated chip-enable goes high again. After each edge, `buf_drive`=1 exactly when the gated chip-enable is low, `host_oe_n`=0, `host_we_n`=1 and the access is not write-first.
- R8: `bat_load` is 1 after powered edges 1 through P, counting from 1. It is 1 again after edges T+1 through T+P, and the pattern repeats with period T. Here P = CLK_HZ*PULSE_MS/1000, T = CLK_HZ*PERIOD_MS/1000 and P < T.
- R9: At the edge that ends a test pulse (powered edge P+1, T+P+1 and so on), `bat_warn` takes the value of `!batt_ok` sampled at that edge. It holds its value at every other edge, whatever `batt_ok` does.
- R10: An unpowered edge clears `bat_load` at that edge and leaves `bat_warn` unchanged. A warning survives supply loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_fail | input | 1 | Debounced supply-fail flag, 1 = failing |
| supply_good | input | 1 | Supply-valid flag, 1 = valid |
| batt_ok | input | 1 | Battery comparator result, 1 = battery good |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| mem_ce_n | output | 1 | Gated chip-enable to the memory |
| mem_we_n | output | 1 | Gated write-enable to the memory |
| buf_drive | output | 1 | 1 = memory output buffers may drive the bus |
| sys_rst | output | 1 | System reset, active high |
| bat_load | output | 1 | Battery load test pulse |
| bat_warn | output | 1 | Latched low-battery warning |

## Verification
Every output is a single register, so each result is due exactly one edge after the inputs that cause it. The bench drives inputs on the falling edge and compares outputs on the next falling edge, after one rising edge has passed. The supply windows are checked on every powered edge from 1 to past the reset release, so the exact edge where each window ends is pinned down. The battery pulse and the warning are checked on every edge across two full test periods. This includes the edge that ends each pulse, the comparator changing between tests, and a supply loss while a warning is latched.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  // Convert a window in milliseconds into clock cycles, never below one.
  function automatic longint unsigned ms_to_cyc(longint unsigned hz, longint unsigned ms);
    longint unsigned c;
    c = (hz * ms) / 64'd1000;
    return (c == 64'd0) ? 64'd1 : c;
  endfunction

  function automatic longint unsigned max3(longint unsigned a, longint unsigned b,
                                           longint unsigned c);
    longint unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwg_upseq.sv
module pwg_upseq #(
  parameter longint unsigned GATE_CYC = 2,
  parameter longint unsigned PROT_CYC = 125,
  parameter longint unsigned RST_CYC  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic powered,
  output logic strobe_blk,
  output logic write_blk,
  output logic sys_rst_q
);
  import pwg_pkg::*;

  localparam longint unsigned MAX_CYC = max3(GATE_CYC, PROT_CYC, RST_CYC);
  localparam int W = $clog2(MAX_CYC + 1);
  localparam logic [W-1:0] GATE_W = W'(GATE_CYC);
  localparam logic [W-1:0] PROT_W = W'(PROT_CYC);
  localparam logic [W-1:0] RST_W  = W'(RST_CYC);
  localparam logic [W-1:0] MAX_W  = W'(MAX_CYC);

  logic [W-1:0] cnt_q, cnt_d;

  // Count powered edges and stop at the longest window; any loss restarts at zero.
  always_comb begin
    if (!powered)            cnt_d = '0;
    else if (cnt_q == MAX_W) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  assign strobe_blk = (cnt_d < GATE_W);
  assign write_blk  = (cnt_d < PROT_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      sys_rst_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      sys_rst_q <= (cnt_d < RST_W);
    end
  end

  assert_loss_resets_R2: assert property (@(posedge clk) disable iff (rst)
    !powered |=> sys_rst_q);

  assert_rst_covers_prot_R5: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_q && powered) |-> !write_blk);

  assert_restart_from_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !powered |=> (cnt_q == '0));

endmodule

// File: rtl/pwg_strobe.sv
module pwg_strobe (
  input  logic clk,
  input  logic rst,
  input  logic strobe_blk,
  input  logic write_blk,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic buf_drive
);
  logic ce_g_n, we_g_n;
  logic wfirst_q, wfirst_d;
  logic drive_d;

  always_comb begin
    ce_g_n = host_ce_n | strobe_blk;
    we_g_n = host_we_n | write_blk | strobe_blk;
    // An access that opens with write-enable already low stays write-first.
    if (ce_g_n)        wfirst_d = 1'b0;
    else if (mem_ce_n) wfirst_d = ~host_we_n;
    else               wfirst_d = wfirst_q;
    drive_d = ~ce_g_n & ~host_oe_n & host_we_n & ~wfirst_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      buf_drive <= 1'b0;
      wfirst_q  <= 1'b0;
    end else begin
      mem_ce_n  <= ce_g_n;
      mem_we_n  <= we_g_n;
      buf_drive <= drive_d;
      wfirst_q  <= wfirst_d;
    end
  end

  assert_block_forces_high_R2: assert property (@(posedge clk) disable iff (rst)
    strobe_blk |=> (mem_ce_n && mem_we_n));

  assert_protect_holds_we_R4: assert property (@(posedge clk) disable iff (rst)
    write_blk |=> mem_we_n);

  assert_drive_only_read_R7: assert property (@(posedge clk) disable iff (rst)
    buf_drive |-> (!mem_ce_n && mem_we_n));

endmodule

// File: rtl/pwg_battest.sv
module pwg_battest #(
  parameter longint unsigned PULSE_CYC  = 1000,
  parameter longint unsigned PERIOD_CYC = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic powered,
  input  logic batt_ok,
  output logic bat_load,
  output logic bat_warn
);
  localparam int PH_W = (PERIOD_CYC < 2) ? 1 : $clog2(PERIOD_CYC);
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0] PULSE_W  = PH_W'(PULSE_CYC);
  localparam logic [PH_W-1:0] END_PH   = PH_W'(PULSE_CYC - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            act_q, act_d;
  logic            end_d;

  always_comb begin
    if (!powered) begin
      act_d = 1'b0;
      ph_d  = '0;
    end else if (!act_q) begin
      act_d = 1'b1;
      ph_d  = '0;
    end else begin
      act_d = 1'b1;
      ph_d  = (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
    end
    end_d = powered & act_q & (ph_q == END_PH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= '0;
      act_q    <= 1'b0;
      bat_load <= 1'b0;
      bat_warn <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      act_q    <= act_d;
      bat_load <= powered & (ph_d < PULSE_W);
      if (end_d) bat_warn <= ~batt_ok;
    end
  end

  assert_load_needs_power_R10: assert property (@(posedge clk) disable iff (rst)
    !powered |=> !bat_load);

  assert_warn_moves_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    !$fell(bat_load) |-> $stable(bat_warn));

  assert_test_starts_powered_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(bat_load) |-> $past(powered));

endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard #(
  parameter longint unsigned CLK_HZ    = 250_000_000,
  parameter longint unsigned GATE_MS   = 2,
  parameter longint unsigned PROT_MS   = 125,
  parameter longint unsigned RST_MS    = 200,
  parameter longint unsigned PULSE_MS  = 1000,
  parameter longint unsigned PERIOD_MS = 86_400_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_fail,
  input  logic supply_good,
  input  logic batt_ok,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic buf_drive,
  output logic sys_rst,
  output logic bat_load,
  output logic bat_warn
);
  import pwg_pkg::*;

  localparam longint unsigned GATE_CYC   = ms_to_cyc(CLK_HZ, GATE_MS);
  localparam longint unsigned PROT_CYC   = ms_to_cyc(CLK_HZ, PROT_MS);
  localparam longint unsigned RST_CYC    = ms_to_cyc(CLK_HZ, RST_MS);
  localparam longint unsigned PULSE_CYC  = ms_to_cyc(CLK_HZ, PULSE_MS);
  localparam longint unsigned PERIOD_CYC = ms_to_cyc(CLK_HZ, PERIOD_MS);

  logic powered;
  logic strobe_blk, write_blk;

  assign powered = supply_good & ~supply_fail;

  pwg_upseq #(
    .GATE_CYC (GATE_CYC),
    .PROT_CYC (PROT_CYC),
    .RST_CYC  (RST_CYC)
  ) u_upseq (
    .clk        (clk),
    .rst        (rst),
    .powered    (powered),
    .strobe_blk (strobe_blk),
    .write_blk  (write_blk),
    .sys_rst_q  (sys_rst)
  );

  pwg_strobe u_strobe (
    .clk        (clk),
    .rst        (rst),
    .strobe_blk (strobe_blk),
    .write_blk  (write_blk),
    .host_ce_n  (host_ce_n),
    .host_we_n  (host_we_n),
    .host_oe_n  (host_oe_n),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .buf_drive  (buf_drive)
  );

  pwg_battest #(
    .PULSE_CYC  (PULSE_CYC),
    .PERIOD_CYC (PERIOD_CYC)
  ) u_battest (
    .clk      (clk),
    .rst      (rst),
    .powered  (powered),
    .batt_ok  (batt_ok),
    .bat_load (bat_load),
    .bat_warn (bat_warn)
  );

  assert_we_needs_power_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> $past(powered));

  assert_ce_needs_power_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> $past(powered));

endmodule

// File: tb/tb_pwrfail_guard.sv
module tb_pwrfail_guard;
  localparam longint unsigned HZ = 1000;
  localparam int G  = 2;
  localparam int PR = 125;
  localparam int RS = 200;
  localparam int P  = 1000;
  localparam int T  = 1500;

  logic clk = 1'b0;
  logic rst, supply_fail, supply_good, batt_ok, host_ce_n, host_we_n, host_oe_n;
  logic mem_ce_n, mem_we_n, buf_drive, sys_rst, bat_load, bat_warn;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwrfail_guard #(
    .CLK_HZ(HZ), .GATE_MS(2), .PROT_MS(125), .RST_MS(200),
    .PULSE_MS(1000), .PERIOD_MS(1500)
  ) dut (
    .clk(clk), .rst(rst), .supply_fail(supply_fail), .supply_good(supply_good),
    .batt_ok(batt_ok), .host_ce_n(host_ce_n), .host_we_n(host_we_n),
    .host_oe_n(host_oe_n), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .buf_drive(buf_drive), .sys_rst(sys_rst), .bat_load(bat_load), .bat_warn(bat_warn)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Per-edge check during a power-up run; k counts powered edges from 1.
  task automatic seq_chk(int k, logic exp_load, logic exp_warn);
    chk("R3 mem_ce_n window", mem_ce_n, (k < G) ? 1'b1 : host_ce_n);
    chk("R4 mem_we_n window", mem_we_n, (k < PR) ? 1'b1 : host_we_n);
    chk("R5 sys_rst window", sys_rst, (k < RS) ? 1'b1 : 1'b0);
    chk("R8 bat_load", bat_load, exp_load);
    chk("R9 bat_warn", bat_warn, exp_warn);
    chk("R7 no drive while we low", buf_drive, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; supply_fail = 1'b1; supply_good = 1'b0; batt_ok = 1'b1;
    host_ce_n = 1'b1; host_we_n = 1'b1; host_oe_n = 1'b1;
    @(negedge clk);
    repeat (3) step();
    chk("R1 mem_ce_n", mem_ce_n, 1'b1);
    chk("R1 mem_we_n", mem_we_n, 1'b1);
    chk("R1 buf_drive", buf_drive, 1'b0);
    chk("R1 sys_rst", sys_rst, 1'b1);
    chk("R1 bat_load", bat_load, 1'b0);
    chk("R1 bat_warn", bat_warn, 1'b0);
    rst = 1'b0;
    step();
    chk("R2 unpowered after reset", sys_rst, 1'b1);
    chk("R2 unpowered ce", mem_ce_n, 1'b1);

    // Phase A: partial power-up, then abort by supply_fail.
    host_ce_n = 1'b0; host_we_n = 1'b0; host_oe_n = 1'b0;
    supply_fail = 1'b0; supply_good = 1'b1;
    for (int k = 1; k <= 50; k++) begin
      step();
      seq_chk(k, 1'b1, 1'b0);
    end
    supply_fail = 1'b1;
    step();
    chk("R2 fail ce", mem_ce_n, 1'b1);
    chk("R2 fail we", mem_we_n, 1'b1);
    chk("R2 fail rst", sys_rst, 1'b1);
    chk("R10 fail load", bat_load, 1'b0);
    chk("R10 fail warn", bat_warn, 1'b0);

    // Phase B: restart from zero (R6), first test with a weak battery.
    supply_fail = 1'b0; batt_ok = 1'b0;
    for (int k = 1; k <= P + 5; k++) begin
      step();
      seq_chk(k, (k <= P), (k >= P + 1));
    end

    // Phase C: supply_good low keeps the latched warning.
    supply_good = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 good-low ce", mem_ce_n, 1'b1);
      chk("R2 good-low we", mem_we_n, 1'b1);
      chk("R2 good-low rst", sys_rst, 1'b1);
      chk("R10 good-low load", bat_load, 1'b0);
      chk("R10 warn kept", bat_warn, 1'b1);
    end

    // Phase D: R6 restart, two test pulses, comparator changed between them.
    supply_good = 1'b1; batt_ok = 1'b1;
    for (int k = 1; k <= T + P + 5; k++) begin
      logic el, ew;
      step();
      el = (k <= P) || ((k >= T + 1) && (k <= T + P));
      ew = (k <= P) ? 1'b1 : ((k <= T + P) ? 1'b0 : 1'b1);
      seq_chk(k, el, ew);
      if (k == P + 10) batt_ok = 1'b0;
    end

    // Phase E: output drive patterns with strobes released.
    host_ce_n = 1'b1; host_we_n = 1'b1; host_oe_n = 1'b1;
    step();
    chk("R7 idle", buf_drive, 1'b0);
    chk("R3 ce follows host", mem_ce_n, 1'b1);
    host_ce_n = 1'b0; host_oe_n = 1'b0;
    step();
    chk("R7 read drives", buf_drive, 1'b1);
    chk("R3 ce low passes", mem_ce_n, 1'b0);
    chk("R4 we high passes", mem_we_n, 1'b1);
    host_we_n = 1'b0;
    step();
    chk("R7 we low in read", buf_drive, 1'b0);
    chk("R4 we low passes", mem_we_n, 1'b0);
    host_we_n = 1'b1;
    step();
    chk("R7 read resumes", buf_drive, 1'b1);
    host_oe_n = 1'b1;
    step();
    chk("R7 oe high", buf_drive, 1'b0);
    host_oe_n = 1'b0; host_ce_n = 1'b1;
    step();
    chk("R7 ce high", buf_drive, 1'b0);
    host_we_n = 1'b0;
    step();
    host_ce_n = 1'b0;
    step();
    chk("R7 write-first", buf_drive, 1'b0);
    host_we_n = 1'b1;
    step();
    chk("R7 write-first held", buf_drive, 1'b0);
    host_ce_n = 1'b1;
    step();
    chk("R7 access ended", buf_drive, 1'b0);
    host_ce_n = 1'b0;
    step();
    chk("R7 fresh read", buf_drive, 1'b1);
    host_ce_n = 1'b1;
    step();
    host_ce_n = 1'b0; host_we_n = 1'b0;
    step();
    chk("R7 simultaneous fall", buf_drive, 1'b0);
    host_we_n = 1'b1;
    step();
    chk("R7 simultaneous held", buf_drive, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule